// File: doc/BRIEF.md
# Multiplexed Bus to Asynchronous SRAM Bridge

This block connects a host whose 16 address/data lines are shared between an address phase and a data phase to an asynchronous SRAM with separate address and data buses. In the address phase the host raises the address latch enable and places the low 16 address bits on the shared lines. The bridge captures them and holds them until the next latch pulse. In the following data phase the host raises read enable or write enable. The bridge then forms the SRAM address and drives the SRAM control strobes. For reads it also returns SRAM data to the host.

A width select chooses between two data modes. In wide mode all 16 shared lines carry data and the SRAM address is the 16 latched bits. In narrow mode the low byte carries data. The high byte carries address bits 23:16, which are captured during the data phase. This gives a 24-bit byte address, enough for a 1 MB memory and beyond. All host inputs are sampled on the block clock, so every output follows its inputs one clock later. The bidirectional shared bus appears as a separate input, output and output-enable, which the pad ring combines.

Top module: `bmx_bridge`

## Requirements
- R1: While rst_n is low, sram_addr, sram_wdata and bus_o are zero, and sram_we, sram_oe, sram_ce and bus_oe are low.
- R2: On a clock edge with host_ale high, sram_addr[15:0] takes bus_i. On every other edge those bits keep their value.
- R3: In narrow mode (host_mode8 = 1), on an edge with host_ale low and host_re or host_we high, the upper address byte takes bus_i[15:8]. sram_addr is then {upper byte, latched low 16 bits}, so every address up to 0x0FFFFF (1 MB) is reachable.
- R4: In wide mode (host_mode8 = 0), sram_addr[23:16] reads as zero and the stored upper byte is not updated.
- R5: sram_we is high one clock after an edge where host_we is high and host_ale is low, and low otherwise.
- R6: sram_oe is high one clock after an edge where host_re is high and host_ale is low, and low otherwise.
- R7: sram_ce is high one clock after an edge where host_re or host_we is high, including during the address phase, and low otherwise.
- R8: bus_oe has the same timing as sram_oe. While bus_oe is low, bus_o is zero.
- R9: While bus_oe is high, bus_o equals sram_rdata in wide mode. In narrow mode it equals {8'h00, sram_rdata[7:0]}, using the mode registered with the strobes.
- R10: On an edge with host_we high and host_ale low, sram_wdata takes bus_i in wide mode, or {8'h00, bus_i[7:0]} in narrow mode. On all other edges it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode8 | input | 1 | 1 = narrow data mode, 0 = wide data mode |
| host_ale | input | 1 | Address latch enable, active high |
| host_re | input | 1 | Host read enable, active high |
| host_we | input | 1 | Host write enable, active high |
| bus_i | input | 16 | Shared lines as seen by the bridge |
| bus_o | output | 16 | Read data returned to the shared lines |
| bus_oe | output | 1 | Bridge drives the shared lines when high |
| sram_addr | output | 24 | SRAM byte/word address |
| sram_wdata | output | 16 | Data toward the SRAM |
| sram_rdata | input | 16 | Data from the SRAM |
| sram_ce | output | 1 | SRAM chip enable, active high |
| sram_we | output | 1 | SRAM write enable, active high |
| sram_oe | output | 1 | SRAM output enable, active high |

## Verification
The bench goes after the overlap of the latch enable with a strobe. A bridge that forgot to gate the strobes would pulse the SRAM write enable while the shared lines still hold an address, and would drive bus_oe against the host. It also checks that the upper byte changes only in a narrow-mode data phase. A design that also sampled it in the address phase or in wide mode would move the access to a wrong 64 KB page. Reads in both modes check that narrow mode clears the top data byte. Idle cycles with changing bus values check that the latched address and the write data hold.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic ce;
        logic we;
        logic oe;
        logic drive;
    } strobe_t;

    function automatic phase_e decode_phase(input logic ale, input logic re, input logic we);
        phase_e ph;
        if (ale)
            ph = PH_ADDR;
        else if (re || we)
            ph = PH_DATA;
        else
            ph = PH_IDLE;
        return ph;
    endfunction

endpackage

// File: rtl/bmx_addr_latch.sv
module bmx_addr_latch
    import bmx_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int HI_W  = 8,
    localparam int ADDR_W = BUS_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              mode8,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              mode8_q,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic [BUS_W-1:0] lo;
        logic [HI_W-1:0]  hi;
        logic             m8;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.m8 = mode8;
        if (phase == PH_ADDR)
            st_d.lo = bus_i;
        if (phase == PH_DATA && mode8)
            st_d.hi = bus_i[BUS_W-1 -: HI_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mode8_q = st_q.m8;
    assign addr    = st_q.m8 ? {st_q.hi, st_q.lo} : {{HI_W{1'b0}}, st_q.lo};

endmodule

// File: rtl/bmx_strobe_gen.sv
module bmx_strobe_gen
    import bmx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  phase_e  phase,
    input  logic    re,
    input  logic    we,
    output strobe_t strb
);

    strobe_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.ce    = re || we;
        st_d.we    = (phase == PH_DATA) && we;
        st_d.oe    = (phase == PH_DATA) && re;
        st_d.drive = (phase == PH_DATA) && re;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign strb = st_q;

endmodule

// File: rtl/bmx_data_path.sv
module bmx_data_path
    import bmx_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int HI_W  = 8,
    localparam int NARROW_W = BUS_W - HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic             we,
    input  logic             mode8,
    input  logic             mode8_q,
    input  logic             drive,
    input  logic [BUS_W-1:0] bus_i,
    input  logic [BUS_W-1:0] rdata,
    output logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] bus_o
);

    logic [BUS_W-1:0] wd_d, wd_q;
    logic [BUS_W-1:0] wr_fmt;
    logic [BUS_W-1:0] rd_fmt;

    generate
        if (NARROW_W < BUS_W) begin : g_split
            assign wr_fmt = mode8   ? {{HI_W{1'b0}}, bus_i[NARROW_W-1:0]} : bus_i;
            assign rd_fmt = mode8_q ? {{HI_W{1'b0}}, rdata[NARROW_W-1:0]} : rdata;
        end else begin : g_full
            assign wr_fmt = bus_i;
            assign rd_fmt = rdata;
        end
    endgenerate

    always_comb begin
        wd_d = wd_q;
        if (phase == PH_DATA && we)
            wd_d = wr_fmt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wd_q <= '0;
        else
            wd_q <= wd_d;
    end

    assign wdata = wd_q;
    assign bus_o = drive ? rd_fmt : '0;

endmodule

// File: rtl/bmx_bridge.sv
module bmx_bridge
    import bmx_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int HI_W  = 8,
    localparam int ADDR_W = BUS_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode8,
    input  logic              host_ale,
    input  logic              host_re,
    input  logic              host_we,
    input  logic [BUS_W-1:0]  bus_i,
    output logic [BUS_W-1:0]  bus_o,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [BUS_W-1:0]  sram_wdata,
    input  logic [BUS_W-1:0]  sram_rdata,
    output logic              sram_ce,
    output logic              sram_we,
    output logic              sram_oe
);

    phase_e  phase;
    strobe_t strb;
    logic    mode8_q;

    assign phase = decode_phase(host_ale, host_re, host_we);

    bmx_addr_latch #(.BUS_W(BUS_W), .HI_W(HI_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .mode8   (host_mode8),
        .bus_i   (bus_i),
        .mode8_q (mode8_q),
        .addr    (sram_addr)
    );

    bmx_strobe_gen u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .re    (host_re),
        .we    (host_we),
        .strb  (strb)
    );

    bmx_data_path #(.BUS_W(BUS_W), .HI_W(HI_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .we      (host_we),
        .mode8   (host_mode8),
        .mode8_q (mode8_q),
        .drive   (strb.drive),
        .bus_i   (bus_i),
        .rdata   (sram_rdata),
        .wdata   (sram_wdata),
        .bus_o   (bus_o)
    );

    assign sram_ce = strb.ce;
    assign sram_we = strb.we;
    assign sram_oe = strb.oe;
    assign bus_oe  = strb.drive;

endmodule

// File: rtl/bmx_bridge_chk.sv
module bmx_bridge_chk #(
    parameter int BUS_W = 16,
    parameter int HI_W  = 8,
    localparam int ADDR_W = BUS_W + HI_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_mode8,
    input logic              host_ale,
    input logic              host_re,
    input logic              host_we,
    input logic [BUS_W-1:0]  bus_i,
    input logic [BUS_W-1:0]  bus_o,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce,
    input logic              sram_we,
    input logic              sram_oe
);

    // R2
    low_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ale |=> $stable(sram_addr[BUS_W-1:0]));

    // R3
    high_byte_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode8 && !host_ale && (host_re || host_we)) |=>
            sram_addr[ADDR_W-1:BUS_W] == $past(bus_i[BUS_W-1 -: HI_W]));

    // R4
    wide_mode_page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode8 |=> sram_addr[ADDR_W-1:BUS_W] == '0);

    // R5
    write_strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ale || !host_we) |=> !sram_we);

    // R6
    read_strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ale || !host_re) |=> !sram_oe);

    // R7
    chip_enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_re && !host_we) |=> !sram_ce);

    // R8
    drive_matches_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe == sram_oe);

    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_o == '0);

endmodule

bind bmx_bridge bmx_bridge_chk #(.BUS_W(BUS_W), .HI_W(HI_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_mode8 (host_mode8),
    .host_ale   (host_ale),
    .host_re    (host_re),
    .host_we    (host_we),
    .bus_i      (bus_i),
    .bus_o      (bus_o),
    .bus_oe     (bus_oe),
    .sram_addr  (sram_addr),
    .sram_ce    (sram_ce),
    .sram_we    (sram_we),
    .sram_oe    (sram_oe)
);

// File: tb/sim_bmx_bridge.sv
module sim_bmx_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic        m8;
        logic        ale;
        logic        re;
        logic        we;
        logic [15:0] bus;
        logic [15:0] rd;
        logic [23:0] addr;
        logic        s_we;
        logic        s_oe;
        logic        s_ce;
        logic        boe;
        logic [15:0] bo;
        logic [15:0] wd;
    } vec_t;

    // m8 ale re we  bus   rdata    addr    we oe ce boe  bus_o   wdata
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b1,1'b0,1'b0,16'h1234,16'h0000,24'h001234,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000},
        '{1'b0,1'b0,1'b0,1'b1,16'hABCD,16'h0000,24'h001234,1'b1,1'b0,1'b1,1'b0,16'h0000,16'hABCD},
        '{1'b0,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,24'h001234,1'b0,1'b0,1'b0,1'b0,16'h0000,16'hABCD},
        '{1'b0,1'b1,1'b0,1'b0,16'h5678,16'h0000,24'h005678,1'b0,1'b0,1'b0,1'b0,16'h0000,16'hABCD},
        '{1'b0,1'b0,1'b1,1'b0,16'h0000,16'hBEEF,24'h005678,1'b0,1'b1,1'b1,1'b1,16'hBEEF,16'hABCD},
        '{1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h0000,24'h00FFFF,1'b0,1'b0,1'b0,1'b0,16'h0000,16'hABCD},
        '{1'b1,1'b0,1'b1,1'b0,16'h0F00,16'h12A5,24'h0FFFFF,1'b0,1'b1,1'b1,1'b1,16'h00A5,16'hABCD},
        '{1'b1,1'b1,1'b0,1'b0,16'h0010,16'h0000,24'h0F0010,1'b0,1'b0,1'b0,1'b0,16'h0000,16'hABCD},
        '{1'b1,1'b0,1'b0,1'b1,16'h8C5A,16'h0000,24'h8C0010,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h005A},
        '{1'b1,1'b1,1'b1,1'b0,16'h2222,16'h9999,24'h8C2222,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h005A},
        '{1'b1,1'b0,1'b1,1'b0,16'h3300,16'h77FF,24'h332222,1'b0,1'b1,1'b1,1'b1,16'h00FF,16'h005A},
        '{1'b0,1'b1,1'b0,1'b1,16'h4444,16'h0000,24'h004444,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h005A},
        '{1'b0,1'b0,1'b0,1'b1,16'h9999,16'h0000,24'h004444,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h9999},
        '{1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,24'h334444,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h9999}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_mode8, host_ale, host_re, host_we;
    logic [15:0] bus_i, bus_o, sram_wdata, sram_rdata;
    logic        bus_oe, sram_ce, sram_we, sram_oe;
    logic [23:0] sram_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmx_bridge u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_mode8 (host_mode8),
        .host_ale   (host_ale),
        .host_re    (host_re),
        .host_we    (host_we),
        .bus_i      (bus_i),
        .bus_o      (bus_o),
        .bus_oe     (bus_oe),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata),
        .sram_ce    (sram_ce),
        .sram_we    (sram_we),
        .sram_oe    (sram_oe)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_reset_state(input string when);
        chk({"R1 addr ", when},  sram_addr, 24'h0);
        chk({"R1 wdata ", when}, {8'h0, sram_wdata}, 24'h0);
        chk({"R1 bus_o ", when}, {8'h0, bus_o}, 24'h0);
        chk({"R1 strobes ", when}, {20'h0, sram_we, sram_oe, sram_ce, bus_oe}, 24'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        host_mode8 = 1'b0; host_ale = 1'b0; host_re = 1'b0; host_we = 1'b0;
        bus_i = 16'h0; sram_rdata = 16'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_reset_state("power-up");
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            host_mode8 = VEC[i].m8;
            host_ale   = VEC[i].ale;
            host_re    = VEC[i].re;
            host_we    = VEC[i].we;
            bus_i      = VEC[i].bus;
            sram_rdata = VEC[i].rd;
            @(negedge clk);
            chk($sformatf("R2/R3/R4 addr v%0d", i), sram_addr, VEC[i].addr);
            chk($sformatf("R5 sram_we v%0d", i), {23'h0, sram_we}, {23'h0, VEC[i].s_we});
            chk($sformatf("R6 sram_oe v%0d", i), {23'h0, sram_oe}, {23'h0, VEC[i].s_oe});
            chk($sformatf("R7 sram_ce v%0d", i), {23'h0, sram_ce}, {23'h0, VEC[i].s_ce});
            chk($sformatf("R8 bus_oe v%0d", i), {23'h0, bus_oe}, {23'h0, VEC[i].boe});
            chk($sformatf("R9 bus_o v%0d", i), {8'h0, bus_o}, {8'h0, VEC[i].bo});
            chk($sformatf("R10 wdata v%0d", i), {8'h0, sram_wdata}, {8'h0, VEC[i].wd});
        end

        // R9: rdata change during an ongoing narrow read reaches bus_o without a clock edge
        host_mode8 = 1'b1; host_ale = 1'b0; host_re = 1'b1; host_we = 1'b0;
        bus_i = 16'h0500; sram_rdata = 16'hAA11;
        @(negedge clk);
        chk("R9 narrow read low byte", {8'h0, bus_o}, 24'h000011);
        sram_rdata = 16'h55C3;
        #1;
        chk("R9 narrow read follows rdata", {8'h0, bus_o}, 24'h0000C3);
        chk("R3 narrow page 05", sram_addr, 24'h054444);

        // R1: asynchronous reset in the middle of an access
        rst_n = 1'b0;
        #1;
        chk_reset_state("mid-access");
        @(negedge clk);
        rst_n = 1'b1;
        host_re = 1'b0; host_mode8 = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule